// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link in front of a byte-wide memory. It brings the serial clock, the select line, the serial input and the pause line into the system clock domain through synchronisers. The first byte of each select window is an 8-bit instruction, and the block decodes it. Bus modes 0 and 3 both work. Input bits are captured when the serial clock rises, and the output bit moves when the serial clock falls.

A read takes a two-byte address and streams array bytes out MSB first. A write takes a two-byte address and passes each complete data byte to the page buffer with its target address. The block also forwards write-latch set and clear requests and a status-register write byte. A read-status request returns the status byte supplied from outside.

While the memory reports an internal write in progress, every instruction except read-status is dropped, and read-status returns all ones. The array, the write latch and the protection policy live outside this block.

The block assumes each serial clock phase lasts at least 4 system clock cycles. It also assumes the pause line moves only while the serial clock is low.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: After reset, `spi_so_oe` is low and none of the pulses `wr_valid`, `wr_commit`, `wel_set`, `wel_clr` or `wrsr_valid` are asserted.
- R2: `spi_so_oe` is low whenever the select line is high. It goes high once the select line is low and no pause is in effect.
- R3: Opcode 03h, followed by a high then a low address byte, starts a read. Only address bits 14:0 are used and bit 15 is ignored. Each following byte on `spi_so` is the array byte at the current address, MSB first. Bits are sampled on rising serial clock edges and change on falling ones, in both idle-low and idle-high clock polarity.
- R4: During a read, the address rises by one per byte across the whole array and wraps from 7FFFh to 0000h.
- R5: Opcode 02h plus two address bytes starts a write. Each complete data byte pulses `wr_valid` with `wr_addr` and `wr_data`. Address bits 5:0 step by one per byte and wrap inside the 64-byte page, while bits 14:6 stay fixed.
- R6: `wr_commit` pulses once when the select line rises after a write that carried at least one complete data byte. Trailing bits that do not form a full byte are dropped. A write with no data byte gives no commit.
- R7: Opcode 05h makes `spi_so` repeat `status_in` byte after byte. While `wr_busy` is high, it returns FFh instead.
- R8: While `wr_busy` is high at instruction decode, every opcode other than 05h is dropped until the select line rises. No pulse results, and `spi_so` shifts zeros.
- R9: Opcode 06h pulses `wel_set`, and opcode 04h pulses `wel_clr`. Opcode 01h passes the next byte out on `wrsr_data` with a `wrsr_valid` pulse. At most one of the five pulses is high in any cycle.
- R10: An opcode outside 01h to 06h makes the rest of the select window be ignored. The next window decodes normally.
- R11: Pulling `spi_hold_n` low while the serial clock is low pauses the transfer. `spi_so_oe` goes low and clock edges are not counted. Releasing it while the clock is low resumes the transfer at the bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, asynchronous |
| spi_cs_n | input | 1 | Select, active low, asynchronous |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for `spi_so`; low means high impedance |
| wr_busy | input | 1 | Internal write cycle in progress |
| status_in | input | 8 | Status byte returned by read-status |
| rd_addr | output | 15 | Array address of the next read byte |
| rd_data | input | 8 | Array byte at `rd_addr`, valid in the same cycle |
| wr_valid | output | 1 | One-cycle pulse: a write byte is presented |
| wr_addr | output | 15 | Target address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse: a write transaction has closed |
| wel_set | output | 1 | One-cycle pulse: set the write latch |
| wel_clr | output | 1 | One-cycle pulse: clear the write latch |
| wrsr_valid | output | 1 | One-cycle pulse: status write byte presented |
| wrsr_data | output | 8 | Status write byte |

## Verification
The hardest case to reach from the pins is a pause that lands partway through a byte of a streamed read. The clock must be low, and the bench must then toggle the serial clock while paused to show those edges are lost. The bench builds this with a bit-level transfer task. At a chosen bit index, it drops the pause line, checks the output enable, toggles the clock twice, and releases the pause before finishing the byte, in both the first and the second streamed byte. The other hard cases are the address wraps at the array top and at a page end. Directed reads at 7FFEh and writes at offset 3Eh of a page cover these, and seeded random transactions in both clock polarities cover the rest.

// File: rtl/spi_mem_pkg.sv
// Shared constants and types for the serial memory command front end.
// Assumes byte-wide transfers with instruction, address and data all MSB first.
package spi_mem_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_WRSR  = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_WRDI  = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_RDSR  = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_WREN  = 8'h06;

    typedef enum logic [2:0] {
        ST_OPC,     // waiting for the instruction byte
        ST_AHI,     // waiting for address high byte
        ST_ALO,     // waiting for address low byte
        ST_RDATA,   // streaming array bytes out
        ST_STAT,    // streaming the status byte out
        ST_WDATA,   // accepting write data bytes
        ST_WSR,     // waiting for the status write byte
        ST_SKIP     // ignoring everything until deselect
    } cmd_state_e;

endpackage

// File: rtl/spi_mem_sync.sv
// Brings the four serial pins into the system clock domain and derives
// qualified serial clock edges, the select level and the pause state.
// Assumes each serial clock phase spans several system clocks and that
// the pause line only moves while the serial clock is low.
module spi_mem_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic cs_n_raw,
    input  logic si_raw,
    input  logic hold_n_raw,
    output logic sel,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_bit,
    output logic held
);

    localparam int LANES = 4;
    // lane order {hold_n, si, cs_n, sck}; idle values seen during reset
    localparam logic [LANES-1:0] IDLE_PAT = 4'b1010;

    logic [LANES-1:0] raw_vec;
    logic [LANES-1:0] synced;
    logic sck_s, cs_n_s, hold_n_s;
    logic sck_prev, cs_n_prev;

    assign raw_vec = {hold_n_raw, si_raw, cs_n_raw, sck_raw};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] sh;
        // Purpose: multi-flop synchroniser for one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= {SYNC_STAGES{IDLE_PAT[g]}};
            else        sh <= {sh[SYNC_STAGES-2:0], raw_vec[g]};
        end
        assign synced[g] = sh[SYNC_STAGES-1];
    end

    assign sck_s    = synced[0];
    assign cs_n_s   = synced[1];
    assign si_bit   = synced[2];
    assign hold_n_s = synced[3];

    // Purpose: remember previous clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev  <= 1'b0;
            cs_n_prev <= 1'b1;
        end else begin
            sck_prev  <= sck_s;
            cs_n_prev <= cs_n_s;
        end
    end

    // Purpose: pause state, updated only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) held <= 1'b0;
        else if (!sck_s)      held <= !hold_n_s;
    end

    assign sel      = !cs_n_s;
    assign cs_rise  = cs_n_s && !cs_n_prev;
    assign sck_rise = sel && !held && sck_s && !sck_prev;
    assign sck_fall = sel && !held && !sck_s && sck_prev;

endmodule

// File: rtl/spi_mem_shift.sv
// Byte assembler for the input bit stream and byte serialiser for the output.
// Input bits enter on qualified rising edges; output bits advance on falling
// edges. Assumes a load request never coincides with a falling edge.
module spi_mem_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si_bit,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              so_bit
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    // Purpose: collect input bits and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh <= {rx_sh[BYTE_W-3:0], si_bit};
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh, si_bit};
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    // Purpose: hold the outgoing byte and present its MSB on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            tx_sh  <= '0;
            so_bit <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_data;
        end else if (sck_fall) begin
            so_bit <= tx_sh[BYTE_W-1];
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_mem_cmd.sv
// Instruction decoder and transaction sequencer. Consumes completed bytes,
// tracks the address, requests output bytes and emits one-cycle pulses
// toward the write path. Assumes rd_data follows rd_addr in the same cycle.
module spi_mem_cmd
    import spi_mem_pkg::*;
#(
    parameter int MEM_AW  = 15,
    parameter int PAGE_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              wr_busy,
    input  logic [BYTE_W-1:0] status_in,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_data,
    output logic [MEM_AW-1:0] rd_addr,
    output logic              rd_active,
    output logic              wr_valid,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              wrsr_valid,
    output logic [BYTE_W-1:0] wrsr_data
);

    cmd_state_e        state;
    logic [BYTE_W-1:0] addr_hi;
    logic [MEM_AW-1:0] addr_q;
    logic              is_write;
    logic              load_pend;
    logic              wrote_any;

    // Purpose: sequence instruction, address and data phases of a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OPC;
            addr_hi    <= '0;
            addr_q     <= '0;
            is_write   <= 1'b0;
            load_pend  <= 1'b0;
            wrote_any  <= 1'b0;
            wr_valid   <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_commit  <= 1'b0;
            wel_set    <= 1'b0;
            wel_clr    <= 1'b0;
            wrsr_valid <= 1'b0;
            wrsr_data  <= '0;
        end else begin
            wr_valid   <= 1'b0;
            wr_commit  <= 1'b0;
            wel_set    <= 1'b0;
            wel_clr    <= 1'b0;
            wrsr_valid <= 1'b0;
            if (!sel) begin
                state     <= ST_OPC;
                load_pend <= 1'b0;
                wrote_any <= 1'b0;
                if (cs_rise && wrote_any) wr_commit <= 1'b1;
            end else begin
                if (load_pend) begin
                    load_pend <= 1'b0;
                    if (state == ST_RDATA) addr_q <= addr_q + MEM_AW'(1);
                end
                if (byte_done) begin
                    unique case (state)
                        ST_OPC: begin
                            if (wr_busy && rx_byte != OPC_RDSR) begin
                                state <= ST_SKIP;
                            end else begin
                                unique case (rx_byte)
                                    OPC_WREN:  begin wel_set <= 1'b1; state <= ST_SKIP; end
                                    OPC_WRDI:  begin wel_clr <= 1'b1; state <= ST_SKIP; end
                                    OPC_RDSR:  begin load_pend <= 1'b1; state <= ST_STAT; end
                                    OPC_WRSR:  state <= ST_WSR;
                                    OPC_READ:  begin is_write <= 1'b0; state <= ST_AHI; end
                                    OPC_WRITE: begin is_write <= 1'b1; state <= ST_AHI; end
                                    default:   state <= ST_SKIP;
                                endcase
                            end
                        end
                        ST_AHI: begin
                            addr_hi <= rx_byte;
                            state   <= ST_ALO;
                        end
                        ST_ALO: begin
                            addr_q <= MEM_AW'({addr_hi, rx_byte});
                            if (is_write) begin
                                state <= ST_WDATA;
                            end else begin
                                state     <= ST_RDATA;
                                load_pend <= 1'b1;
                            end
                        end
                        ST_RDATA, ST_STAT: load_pend <= 1'b1;
                        ST_WDATA: begin
                            wr_valid  <= 1'b1;
                            wr_addr   <= addr_q;
                            wr_data   <= rx_byte;
                            wrote_any <= 1'b1;
                            addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + PAGE_AW'(1);
                        end
                        ST_WSR: begin
                            wrsr_valid <= 1'b1;
                            wrsr_data  <= rx_byte;
                            state      <= ST_SKIP;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Purpose: choose the byte handed to the serialiser.
    always_comb begin
        if (state == ST_STAT) tx_data = wr_busy ? '1 : status_in;
        else                  tx_data = rd_data;
    end

    assign tx_load   = load_pend;
    assign rd_addr   = addr_q;
    assign rd_active = (state == ST_RDATA);

endmodule

// File: rtl/spi_mem_cmd_if.sv
// Top of the serial memory command front end: synchroniser, bit/byte
// shifter and instruction sequencer. Assumes serial clock phases of at
// least four system clocks.
module spi_mem_cmd_if #(
    parameter int SYNC_STAGES = 2,
    parameter int MEM_AW      = 15,
    parameter int PAGE_AW     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_si,
    input  logic        spi_hold_n,
    output logic        spi_so,
    output logic        spi_so_oe,
    input  logic        wr_busy,
    input  logic [7:0]  status_in,
    output logic [MEM_AW-1:0] rd_addr,
    input  logic [7:0]  rd_data,
    output logic        wr_valid,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        wr_commit,
    output logic        wel_set,
    output logic        wel_clr,
    output logic        wrsr_valid,
    output logic [7:0]  wrsr_data
);

    localparam int BW = spi_mem_pkg::BYTE_W;

    logic          sel, cs_rise, sck_rise, sck_fall, si_bit, held;
    logic          byte_done, tx_load, rd_active;
    logic [BW-1:0] rx_byte, tx_data;

    spi_mem_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_raw(spi_sck), .cs_n_raw(spi_cs_n), .si_raw(spi_si), .hold_n_raw(spi_hold_n),
        .sel(sel), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .si_bit(si_bit), .held(held)
    );

    spi_mem_shift #(.BYTE_W(BW)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_bit(si_bit),
        .tx_load(tx_load), .tx_data(tx_data),
        .byte_done(byte_done), .rx_byte(rx_byte), .so_bit(spi_so)
    );

    spi_mem_cmd #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cs_rise(cs_rise),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .wr_busy(wr_busy), .status_in(status_in), .rd_data(rd_data),
        .tx_load(tx_load), .tx_data(tx_data), .rd_addr(rd_addr), .rd_active(rd_active),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .wel_set(wel_set), .wel_clr(wel_clr), .wrsr_valid(wrsr_valid), .wrsr_data(wrsr_data)
    );

    assign spi_so_oe = sel && !held;

endmodule

// File: rtl/spi_mem_cmd_if_chk.sv
// Property checker for the command front end, attached by bind below.
// Assumes the top's internal select and read-phase signals are visible.
module spi_mem_cmd_if_chk #(
    parameter int SYNC_STAGES = 2,
    parameter int MEM_AW      = 15,
    parameter int PAGE_AW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_so_oe,
    input logic              sel,
    input logic              rd_active,
    input logic [MEM_AW-1:0] rd_addr,
    input logic              wr_valid,
    input logic [MEM_AW-1:0] wr_addr,
    input logic              wr_commit,
    input logic              wel_set,
    input logic              wel_clr,
    input logic              wrsr_valid
);

    logic              has_prev;
    logic [MEM_AW-1:0] prev_addr;
    logic              seen_wr;

    // Purpose: remember the last write address inside the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            has_prev  <= 1'b0;
            prev_addr <= '0;
        end else if (wr_valid) begin
            has_prev  <= 1'b1;
            prev_addr <= wr_addr;
        end
    end

    // Purpose: note whether a write byte went out since the last commit.
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_wr <= 1'b0;
        else if (wr_commit) seen_wr <= 1'b0;
        else if (wr_valid)  seen_wr <= 1'b1;
    end

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_so_oe |-> !$past(spi_cs_n, SYNC_STAGES)); // R2

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, wr_commit, wel_set, wel_clr, wrsr_valid})); // R9

    AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active) && rd_addr != $past(rd_addr))
        |-> rd_addr == $past(rd_addr) + MEM_AW'(1)); // R4

    AST_WR_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && has_prev) |->
        wr_addr == {prev_addr[MEM_AW-1:PAGE_AW], prev_addr[PAGE_AW-1:0] + PAGE_AW'(1)}); // R5

    AST_COMMIT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> seen_wr); // R6

endmodule

bind spi_mem_cmd_if spi_mem_cmd_if_chk #(
    .SYNC_STAGES(SYNC_STAGES), .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
    .sel(sel), .rd_active(rd_active), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_commit(wr_commit),
    .wel_set(wel_set), .wel_clr(wel_clr), .wrsr_valid(wrsr_valid)
);

// File: tb/spi_mem_cmd_if_bench.sv
// Bench for the command front end: seeded random transactions plus directed
// corner cases, every result compared with values derived in bench functions.
module spi_mem_cmd_if_bench;

    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
    logic        spi_so, spi_so_oe;
    logic        wr_busy = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic [14:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_valid, wr_commit, wel_set, wel_clr, wrsr_valid;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data, wrsr_data;

    int total = 0, bad = 0;
    bit done = 1'b0;
    bit mode3 = 1'b0;
    int n_wr = 0, n_commit = 0, n_set = 0, n_clr = 0, n_wsr = 0;
    logic [14:0] log_a [256];
    logic [7:0]  log_d [256];
    logic [7:0]  last_wsr = 8'h00;
    logic [7:0]  wdat [16];
    bit hold_oe_seen;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    function automatic logic [14:0] page_step(input logic [14:0] a, input int k);
        logic [5:0] lo = a[5:0] + 6'(k);
        return {a[14:6], lo};
    endfunction

    assign rd_data = mem_f(rd_addr);

    spi_mem_cmd_if u_spi_mem_cmd_if (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .wr_busy(wr_busy), .status_in(status_in), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .wel_set(wel_set), .wel_clr(wel_clr), .wrsr_valid(wrsr_valid), .wrsr_data(wrsr_data)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                log_a[n_wr[7:0]] <= wr_addr;
                log_d[n_wr[7:0]] <= wr_data;
                n_wr <= n_wr + 1;
            end
            if (wr_commit)  n_commit <= n_commit + 1;
            if (wel_set)    n_set <= n_set + 1;
            if (wel_clr)    n_clr <= n_clr + 1;
            if (wrsr_valid) begin n_wsr <= n_wsr + 1; last_wsr <= wrsr_data; end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic cs_low();
        spi_sck = mode3;
        waitc(4);
        spi_cs_n = 1'b0;
        waitc(6);
    endtask

    task automatic cs_high();
        spi_sck = 1'b0;
        if (mode3) spi_sck = 1'b1;
        waitc(HP);
        spi_cs_n = 1'b1;
        waitc(10);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_sck = 1'b0;
            spi_si  = tx[i];
            waitc(HP);
            if (i == hold_at) begin
                spi_hold_n = 1'b0;
                waitc(6);
                if (spi_so_oe) hold_oe_seen = 1'b1;
                for (int t = 0; t < 2; t++) begin
                    spi_sck = 1'b1; waitc(HP);
                    spi_sck = 1'b0; waitc(HP);
                end
                spi_hold_n = 1'b1;
                waitc(6);
            end
            rx[i] = spi_so;
            spi_sck = 1'b1;
            waitc(HP);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] dummy;
        xfer(tx, -1, dummy);
    endtask

    task automatic part_bits(input int n);
        for (int i = 0; i < n; i++) begin
            spi_sck = 1'b0; spi_si = 1'b1; waitc(HP);
            spi_sck = 1'b1; waitc(HP);
        end
    endtask

    task automatic do_read(input logic [15:0] a16, input int n, input string tag);
        logic [7:0] rx;
        logic [14:0] a = a16[14:0];
        cs_low();
        send(8'h03); send(a16[15:8]); send(a16[7:0]);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, -1, rx);
            chk(rx == mem_f(a + 15'(k)), tag, rx, mem_f(a + 15'(k)));
        end
        cs_high();
    endtask

    task automatic do_write(input logic [15:0] a16, input int n, input int extra, input string tag);
        int w0 = n_wr, c0 = n_commit;
        logic [14:0] a = a16[14:0];
        cs_low();
        send(8'h02); send(a16[15:8]); send(a16[7:0]);
        for (int k = 0; k < n; k++) send(wdat[k]);
        part_bits(extra);
        cs_high();
        chk(n_wr - w0 == n, {tag, " count"}, n_wr - w0, n);
        for (int k = 0; k < n; k++) begin
            chk(log_a[8'(w0 + k)] == page_step(a, k), {tag, " addr"}, log_a[8'(w0 + k)], page_step(a, k));
            chk(log_d[8'(w0 + k)] == wdat[k], {tag, " data"}, log_d[8'(w0 + k)], wdat[k]);
        end
        chk(n_commit - c0 == ((n > 0) ? 1 : 0), "R6 commit count", n_commit - c0, (n > 0) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int s0, c0, w0;
        void'($urandom(32'd7361));
        for (int k = 0; k < 16; k++) wdat[k] = 8'($urandom);
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        chk(!spi_so_oe, "R1 oe after reset", spi_so_oe, 0);
        chk(!wr_valid && !wr_commit && !wel_set && !wel_clr && !wrsr_valid,
            "R1 pulses after reset", 1, 0);

        // R2 select gating of output enable
        chk(!spi_so_oe, "R2 oe with select high", spi_so_oe, 0);
        cs_low();
        chk(spi_so_oe, "R2 oe with select low", spi_so_oe, 1);
        cs_high();
        chk(!spi_so_oe, "R2 oe after deselect", spi_so_oe, 0);

        // R3 reads in both polarities, bit 15 ignored
        mode3 = 1'b0; do_read(16'h1234, 3, "R3 read mode0");
        mode3 = 1'b1; do_read(16'h0ABC, 3, "R3 read mode3");
        mode3 = 1'b0; do_read(16'hC010, 2, "R3 read addr bit15 ignored");

        // R4 wrap at array top
        do_read(16'h7FFE, 4, "R4 read wrap");

        // R5 write with page wrap, R6 commit
        do_write(16'h2345, 3, 0, "R5 write");
        mode3 = 1'b1;
        do_write(16'h1A3E, 5, 0, "R5 write page wrap");
        mode3 = 1'b0;
        do_write(16'h0100, 2, 3, "R6 write partial tail");
        do_write(16'h0200, 0, 0, "R6 write no data");

        // R7 status read, idle and busy
        status_in = 8'h9A;
        cs_low(); send(8'h05);
        xfer(8'h00, -1, rx); chk(rx == 8'h9A, "R7 status byte 1", rx, 8'h9A);
        xfer(8'h00, -1, rx); chk(rx == 8'h9A, "R7 status byte 2", rx, 8'h9A);
        cs_high();
        wr_busy = 1'b1;
        cs_low(); send(8'h05);
        xfer(8'h00, -1, rx); chk(rx == 8'hFF, "R7 status while busy", rx, 8'hFF);
        cs_high();

        // R8 everything else dropped while busy
        s0 = n_set; c0 = n_commit; w0 = n_wr;
        cs_low(); send(8'h06); cs_high();
        do_write_busy: begin
            cs_low(); send(8'h02); send(8'h00); send(8'h10); send(8'h55); send(8'h66); cs_high();
        end
        cs_low(); send(8'h03); send(8'h00); send(8'h20);
        xfer(8'h00, -1, rx); chk(rx == 8'h00, "R8 read while busy shifts zeros", rx, 0);
        cs_high();
        cs_low(); send(8'h01); send(8'h77); cs_high();
        chk(n_set == s0, "R8 no latch set while busy", n_set - s0, 0);
        chk(n_wr == w0 && n_commit == c0, "R8 no write while busy", n_wr - w0, 0);
        chk(last_wsr != 8'h77, "R8 no status write while busy", last_wsr, 0);
        wr_busy = 1'b0;

        // R9 latch control and status write
        s0 = n_set;
        cs_low(); send(8'h06); cs_high();
        chk(n_set == s0 + 1, "R9 set latch", n_set - s0, 1);
        s0 = n_clr;
        mode3 = 1'b1;
        cs_low(); send(8'h04); cs_high();
        chk(n_clr == s0 + 1, "R9 clear latch", n_clr - s0, 1);
        s0 = n_wsr;
        cs_low(); send(8'h01); send(8'hC3); cs_high();
        chk(n_wsr == s0 + 1 && last_wsr == 8'hC3, "R9 status write", last_wsr, 8'hC3);
        mode3 = 1'b0;

        // R10 unknown opcode
        s0 = n_wr; c0 = n_set;
        cs_low(); send(8'hAB); send(8'h02); send(8'h06); send(8'h11); cs_high();
        chk(n_wr == s0 && n_set == c0, "R10 unknown opcode ignored", n_wr - s0, 0);
        do_read(16'h0333, 1, "R10 next window decodes");

        // R11 pause within streamed read
        hold_oe_seen = 1'b0;
        cs_low(); send(8'h03); send(8'h05); send(8'h5A);
        xfer(8'h00, 4, rx); chk(rx == mem_f(15'h055A), "R11 byte across pause", rx, mem_f(15'h055A));
        xfer(8'h00, 7, rx); chk(rx == mem_f(15'h055B), "R11 resume next byte", rx, mem_f(15'h055B));
        cs_high();
        chk(!hold_oe_seen, "R11 oe low during pause", hold_oe_seen, 0);

        // random mix
        for (int it = 0; it < 8; it++) begin
            logic [15:0] ra = 16'($urandom);
            mode3 = 1'($urandom);
            if ($urandom % 2 == 0) do_read(ra, 1 + int'($urandom % 4), "R3 random read");
            else                   do_write(ra, 1 + int'($urandom % 5), 0, "R5 random write");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule